// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter built from identical 4-bit slices. Each slice can be cleared at once by an active-low reset. It can be preset from a parallel data bus on a rising clock edge. Two active-high enables gate its counting. The first enable, called the parallel enable here, is shared by every slice. The second, the trickle enable, also qualifies the slice's terminal-count flag.

The top module chains `NUM_STAGES` slices. Each slice takes its trickle enable from the terminal count of the slice below it. All slices share the clock, the reset, the load control and the parallel enable. Because the carry is a combinational terminal-count path rather than a rippled clock, every slice changes on the same clock edge. The chain therefore behaves as one `NUM_STAGES*STAGE_W`-bit counter.

Top module: `casc_counter`

## Requirements
- R1: While `rstN` is low, `countOut` is zero at once, whatever the clock does, and reset outranks a pending load.
- R2: With `rstN` high and `loadN` low, the rising clock edge copies `presetIn` into `countOut`, whatever the two enables are.
- R3: With `loadN` high and both `cntEnP` and `cntEnT` high, each rising edge adds one to `countOut`.
- R4: With `loadN` high and either enable low, `countOut` holds its value across the edge.
- R5: A count step from all ones gives all zeros.
- R6: `termOut` is high exactly when `cntEnT` is high and `countOut` is all ones. It does not depend on `cntEnP`.
- R7: A carry crosses each slice boundary on the same edge: slice k advances only when every lower slice is all ones.
- R8: On a load, slice k takes `presetIn[STAGE_W*k +: STAGE_W]`, and all slices load together.
- R9: During uninterrupted counting, `termOut` is high for exactly one clock period per wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; loading and counting happen on its rising edge |
| rstN | input | 1 | Asynchronous clear, active low |
| loadN | input | 1 | Synchronous parallel load, active low |
| presetIn | input | NUM_STAGES*STAGE_W | Preset value |
| cntEnP | input | 1 | Parallel count enable, shared by all slices |
| cntEnT | input | 1 | Trickle count enable into the lowest slice |
| countOut | output | NUM_STAGES*STAGE_W | Current count |
| termOut | output | 1 | Terminal count of the highest slice |

## Verification
A load, a count step or a hold shows on `countOut` one edge after the inputs are set up, because one register stage sits in the path. The bench drives inputs on the falling edge and updates its reference integer at the next rising edge. It compares at the following falling edge. Reset and `termOut` are combinational toward the outputs, so the bench checks them within the same half-cycle: `termOut` against the trickle enable still being applied, and reset a nanosecond after `rstN` falls between edges.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef struct packed {
    logic load;
    logic advance;
  } cntStrobe_t;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
#(
  parameter int STAGE_W = 4
) (
  input  logic               loadN,
  input  logic               enP,
  input  logic               enT,
  input  logic [STAGE_W-1:0] curQ,
  output cntStrobe_t         strb,
  output logic               tcOut
);
  // Load outranks counting; counting needs both enables.
  always_comb begin
    strb.load    = !loadN;
    strb.advance = loadN && enP && enT;
    tcOut        = enT && (&curQ);
  end
endmodule

// File: rtl/cnt_datapath.sv
module cnt_datapath
  import cnt_pkg::*;
#(
  parameter int STAGE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  cntStrobe_t         strb,
  input  logic [STAGE_W-1:0] presetVal,
  output logic [STAGE_W-1:0] q
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             q <= '0;
    else if (strb.load)    q <= presetVal;
    else if (strb.advance) q <= q + 1'b1;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int STAGE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadN,
  input  logic               enP,
  input  logic               enT,
  input  logic [STAGE_W-1:0] presetVal,
  output logic [STAGE_W-1:0] q,
  output logic               tcOut
);
  cntStrobe_t strb;

  cnt_ctrl #(.STAGE_W(STAGE_W)) u_ctrl (
    .loadN(loadN), .enP(enP), .enT(enT), .curQ(q),
    .strb(strb), .tcOut(tcOut)
  );

  cnt_datapath #(.STAGE_W(STAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .presetVal(presetVal), .q(q)
  );
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int NUM_STAGES = 3,
  parameter int STAGE_W    = 4,
  localparam int TOTAL_W   = NUM_STAGES * STAGE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadN,
  input  logic [TOTAL_W-1:0] presetIn,
  input  logic               cntEnP,
  input  logic               cntEnT,
  output logic [TOTAL_W-1:0] countOut,
  output logic               termOut
);
  // carryChain[k] is the trickle enable of slice k; carryChain[NUM_STAGES] is the top flag.
  logic [NUM_STAGES:0] carryChain;

  assign carryChain[0] = cntEnT;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    cnt_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk(clk),
      .rstN(rstN),
      .loadN(loadN),
      .enP(cntEnP),
      .enT(carryChain[k]),
      .presetVal(presetIn[STAGE_W*k +: STAGE_W]),
      .q(countOut[STAGE_W*k +: STAGE_W]),
      .tcOut(carryChain[k+1])
    );
  end

  assign termOut = carryChain[NUM_STAGES];
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int NUM_STAGES = 3,
  parameter int STAGE_W    = 4,
  localparam int TOTAL_W   = NUM_STAGES * STAGE_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               loadN,
  input logic [TOTAL_W-1:0] presetIn,
  input logic               cntEnP,
  input logic               cntEnT,
  input logic [TOTAL_W-1:0] countOut,
  input logic               termOut
);
  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEARS: assert (countOut == '0); // R1
    end
    AST_TERM_FLAG: assert (termOut == (cntEnT && (&countOut))); // R6
  end

  AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> countOut == $past(presetIn)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && cntEnP && cntEnT) |=> countOut == TOTAL_W'($past(countOut) + 1'b1)); // R3

  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !(cntEnP && cntEnT)) |=> $stable(countOut)); // R4

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && cntEnP && cntEnT && (&countOut)) |=> countOut == '0); // R5
endmodule

bind casc_counter casc_counter_chk #(.NUM_STAGES(NUM_STAGES), .STAGE_W(STAGE_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadN(loadN), .presetIn(presetIn),
  .cntEnP(cntEnP), .cntEnT(cntEnT), .countOut(countOut), .termOut(termOut)
);

// File: tb/casc_counter_bench.sv
`timescale 1ns/1ps
module casc_counter_bench;
  localparam int NUM_STAGES = 3;
  localparam int STAGE_W    = 4;
  localparam int TOTAL_W    = NUM_STAGES * STAGE_W;
  localparam logic [TOTAL_W-1:0] ALL_ONES = '1;

  logic               clk = 1'b0;
  logic               rstN;
  logic               loadN;
  logic [TOTAL_W-1:0] presetIn;
  logic               cntEnP;
  logic               cntEnT;
  logic [TOTAL_W-1:0] countOut;
  logic               termOut;

  logic [TOTAL_W-1:0] refCnt;
  int numChecks = 0;
  int numFails  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  casc_counter #(.NUM_STAGES(NUM_STAGES), .STAGE_W(STAGE_W)) u_casc_counter (
    .clk(clk), .rstN(rstN), .loadN(loadN), .presetIn(presetIn),
    .cntEnP(cntEnP), .cntEnT(cntEnT), .countOut(countOut), .termOut(termOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge: apply inputs, model the rising edge, then compare at the next falling edge.
  task automatic step(input logic ld, input logic p, input logic t, input logic [TOTAL_W-1:0] pv,
                      input string req);
    loadN = ld; cntEnP = p; cntEnT = t; presetIn = pv;
    @(posedge clk);
    if (!ld)        refCnt = pv;
    else if (p && t) refCnt = refCnt + 1'b1;
    @(negedge clk);
    check(req, 32'(countOut), 32'(refCnt));
    check({req, " R6 term"}, 32'(termOut), 32'(t && (refCnt == ALL_ONES)));
  endtask

  task automatic t_reset_mid();
    step(1'b0, 1'b1, 1'b1, 12'h3C7, "R2 load before reset");
    #2 rstN = 1'b0;
    #1 check("R1 async clear", 32'(countOut), 32'h0);
    check("R1 term low", 32'(termOut), 32'h0);
    loadN = 1'b0; presetIn = 12'h5A5;
    @(posedge clk); @(negedge clk);
    check("R1 reset beats load", 32'(countOut), 32'h0);
    refCnt = '0;
    rstN = 1'b1; loadN = 1'b1;
  endtask

  task automatic t_load();
    step(1'b0, 1'b1, 1'b1, 12'hA5C, "R2 R8 load with enables high");
    step(1'b0, 1'b0, 1'b0, 12'h1E7, "R2 R8 load with enables low");
  endtask

  task automatic t_count();
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, 12'h000, "R3 count step");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 12'h000, "R4 hold enP low");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 12'h000, "R4 hold enT low");
    step(1'b0, 1'b0, 1'b1, ALL_ONES, "R2 load all ones");
    step(1'b1, 1'b0, 1'b1, 12'h000, "R6 term with enP low");
    step(1'b1, 1'b1, 1'b0, 12'h000, "R6 term gated by enT");
  endtask

  task automatic t_wrap();
    int highCycles = 0;
    step(1'b0, 1'b1, 1'b1, ALL_ONES - 12'd2, "R2 preset near wrap");
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1, 1'b1, 12'h000, "R5 R9 wrap");
      if (termOut) highCycles++;
    end
    check("R5 reached zero region", 32'(countOut), 32'h1);
    check("R9 term one period", 32'(highCycles), 32'd1);
  endtask

  task automatic t_carry();
    for (int k = 1; k < NUM_STAGES; k++) begin
      logic [TOTAL_W-1:0] below;
      below = (TOTAL_W'(1) << (STAGE_W*k)) - 1'b1;
      step(1'b0, 1'b1, 1'b1, below, "R8 preset below boundary");
      step(1'b1, 1'b1, 1'b1, 12'h000, "R7 carry across boundary");
      check("R7 carry value", 32'(countOut), 32'(TOTAL_W'(1) << (STAGE_W*k)));
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  endtask

  initial begin
    rstN = 1'b0; loadN = 1'b1; cntEnP = 1'b0; cntEnT = 1'b0; presetIn = '0; refCnt = '0;
    repeat (2) @(negedge clk);
    check("R1 reset state", 32'(countOut), 32'h0);
    check("R1 reset term", 32'(termOut), 32'h0);
    rstN = 1'b1;
    t_load();
    t_count();
    t_reset_mid();
    t_count();
    t_hold();
    t_wrap();
    t_carry();
    done = 1'b1;
    finishRun();
  end

  initial begin
    #500us;
    if (!done) begin
      numChecks++;
      numFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end
endmodule